// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers up to sixteen interrupt requests into a single interrupt line for a processor. It holds two identical eight-input controller cores. One is the primary. The other is the secondary, whose interrupt output feeds the primary's cascade input. Software reaches each core through a pair of byte registers: a command port and a data port. A chip-select bit picks the core. After reset or a re-initialisation, a short fixed sequence of setup words is written to a core. That sequence sets the vector base and the cascade wiring. Later writes to the data port load the mask. Later writes to the command port issue end-of-service commands or pick which register the command port reads back.

A request is latched on the rising edge of its input. The core signals the processor when an unmasked request outranks everything already in service. The processor answers with two acknowledge pulses. The first pulse freezes the winning level and moves it into service. The second pulse makes the block return a vector byte: the programmed base combined with the level number. When the primary's winner is its cascade input, the secondary supplies the vector. If a request vanishes before the first acknowledge, the block reports level 7 and marks no service bit for it. A spurious request that arrives through the secondary still leaves the primary's cascade level in service.

Top module: `pic_pair`

## Requirements
- R1: After reset, each core has its request and in-service registers at zero and its mask at 0xFF, and its command port reads back the request register. `intr_o` and `vec_valid_o` are low.
- R2: A command-port write with bit 4 set starts setup and clears the core's request and in-service registers and its readback selection. The next data-port write is the vector base. A cascade word follows only when bit 1 of the start word is 0. A final word follows only when bit 0 of the start word is 1. Each later data-port write loads the mask.
- R3: The vector equals the base with its low 3 bits cleared, ORed with the serviced level. It appears on `vec_o` with `vec_valid_o` high for exactly the one cycle after the clock edge that sampled the second acknowledge pulse.
- R4: A mask bit at 1 blocks its input from raising `intr_o`, although the request is still latched. A data-port read returns the mask.
- R5: A request bit is set only by a rising input. It clears when a non-cascade input falls. An input that stays high after its acknowledge raises no new request.
- R6: Among unmasked requests, the lowest index wins. A request is considered only when its index is below every level in service, so an equal or lower-priority level waits until the end-of-service command.
- R7: The first acknowledge pulse clears the winner's request bit and sets its in-service bit. `intr_o` is low until the second pulse has been taken.
- R8: A command-port write with bits 7:5 = 011 and bit 4 = bit 3 = 0 clears the in-service bit named by bits 2:0. Other codes with bits 4:3 = 00 leave the in-service register unchanged.
- R9: A command-port write with bit 4 = 0, bit 3 = 1 and bit 1 = 1 makes command-port reads return the in-service register when bit 0 = 1, and the request register when bit 0 = 0. With bit 1 = 0 the selection is kept.
- R10: When bit 2 of the primary's cascade word is set and the primary is not in single mode, primary input 2 follows the secondary's interrupt output. An acknowledge of that level is passed to the secondary when the secondary's cascade word equals 2. The secondary then supplies the vector, and primary in-service bit 2 stays set until an end-of-service command for level 2 reaches the primary.
- R11: If no request is eligible at the first acknowledge pulse, the vector is base|7 and no in-service bit is set. A cascade level's request bit is kept when the secondary's output falls, so a secondary spurious request yields the secondary's base|7 and still sets primary in-service bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_m_i | input | 8 | Primary core request inputs |
| irq_s_i | input | 8 | Secondary core request inputs |
| sel_slave_i | input | 1 | Register access target: 0 primary, 1 secondary |
| a0_i | input | 1 | Register select: 0 command port, 1 data port |
| wr_i | input | 1 | Register write strobe, one cycle per write |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data of the selected port of the selected core |
| inta_i | input | 1 | Acknowledge pulse, one cycle each, two per interrupt |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector byte |
| vec_valid_o | output | 1 | Vector byte valid |

## Verification
On every cycle, the assertions check these properties:
- The vector strobe is a single-cycle pulse that follows an acknowledge.
- In-service bits appear only after an acknowledge, at most one per cycle.
- The secondary marks the level it had picked.
- In-service bits clear only after a command-port write to that core.
- The secondary is mid-acknowledge only when the cascade route is taken.

The actual vector values, the priority order and its blocking by levels in service, and masking need the directed scenarios. So do the two-step end-of-service for cascaded levels, the spurious level-7 reports and the readback selection.

// File: rtl/pic_pkg.sv
// Shared constants and types of the interrupt controller.
// Assumes 8-bit register ports; the bit positions are fixed by the command encoding.
package pic_pkg;
    localparam int DATA_W      = 8;
    localparam int CMD_INIT_B  = 4;   // start-of-setup marker
    localparam int CMD_OCW3_B  = 3;   // readback-select marker
    localparam int START_IC4_B = 0;   // final setup word follows
    localparam int START_SNG_B = 1;   // single mode, no cascade word
    localparam int RDSEL_EN_B  = 1;   // readback selection enable
    localparam int RDSEL_ISR_B = 0;   // 1: in-service, 0: request
    localparam logic [2:0] EOI_SPECIFIC = 3'b011;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_LAST = 2'd3
    } setup_st_e;
endpackage

// File: rtl/pic_prio.sv
// Fixed-priority resolver: the lowest set index wins.
// Assumes N is a power of two no larger than 2**LVL_W.
module pic_prio #(
    parameter int N     = 8,
    parameter int LVL_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [LVL_W-1:0] idx_o
);
    // Scan from the top down so the lowest set index is left in idx_o.
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = LVL_W'(i);
        end
    end
endmodule

// File: rtl/pic_cfg.sv
// Register-port decoder of one core: setup sequence, mask, readback selection,
// end-of-service decode. Assumes single-cycle write strobes.
module pic_cfg
    import pic_pkg::*;
#(
    parameter int N     = 8,
    parameter int LVL_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              a0_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] base_o,
    output logic [DATA_W-1:0] cas_o,
    output logic [N-1:0]      imr_o,
    output logic              rd_isr_o,
    output logic              init_o,
    output logic              eoi_o,
    output logic [LVL_W-1:0]  eoi_lvl_o
);
    localparam logic [DATA_W-1:0] BASE_MASK = ~DATA_W'((1 << LVL_W) - 1);

    setup_st_e         st_q;
    logic              need_last_q;
    logic              single_q;
    logic [DATA_W-1:0] cas_q;
    logic              cmd_wr;
    logic              data_wr;

    assign cmd_wr    = wr_i && !a0_i;
    assign data_wr   = wr_i && a0_i;
    assign init_o    = cmd_wr && wdata_i[CMD_INIT_B];
    assign eoi_o     = cmd_wr && !wdata_i[CMD_INIT_B] && !wdata_i[CMD_OCW3_B]
                       && (wdata_i[7:5] == EOI_SPECIFIC);
    assign eoi_lvl_o = wdata_i[LVL_W-1:0];
    assign cas_o     = single_q ? '0 : cas_q;

    // Setup sequencer and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_RUN;
            need_last_q <= 1'b0;
            single_q    <= 1'b0;
            cas_q       <= '0;
            base_o      <= '0;
            imr_o       <= '1;
            rd_isr_o    <= 1'b0;
        end else if (init_o) begin
            st_q        <= ST_BASE;
            need_last_q <= wdata_i[START_IC4_B];
            single_q    <= wdata_i[START_SNG_B];
            rd_isr_o    <= 1'b0;
        end else if (cmd_wr && wdata_i[CMD_OCW3_B] && wdata_i[RDSEL_EN_B]) begin
            rd_isr_o <= wdata_i[RDSEL_ISR_B];
        end else if (data_wr) begin
            unique case (st_q)
                ST_BASE: begin
                    base_o <= wdata_i & BASE_MASK;
                    if (!single_q)        st_q <= ST_CASC;
                    else if (need_last_q) st_q <= ST_LAST;
                    else                  st_q <= ST_RUN;
                end
                ST_CASC: begin
                    cas_q <= wdata_i;
                    st_q  <= need_last_q ? ST_LAST : ST_RUN;
                end
                ST_LAST: st_q <= ST_RUN;
                default: imr_o <= wdata_i[N-1:0];
            endcase
        end
    end
endmodule

// File: rtl/pic_core.sv
// One eight-input controller core: edge latching, nested priority,
// two-pulse acknowledge, vector build. Non-slave cores keep a cascade
// level's request when its line falls. Assumes ack_i pulses come in pairs.
module pic_core
    import pic_pkg::*;
#(
    parameter int N        = 8,
    parameter bit IS_SLAVE = 1'b0,
    parameter int LVL_W    = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              a0_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      in_i,
    input  logic              ack_i,
    output logic              intr_o,
    output logic [LVL_W-1:0]  pick_o,
    output logic              phase_o,
    output logic [N-1:0]      isr_o,
    output logic [DATA_W-1:0] cas_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] vec_o,
    output logic              vv_o
);
    localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(N - 1);

    logic [DATA_W-1:0] base;
    logic [N-1:0]      imr;
    logic              rd_isr;
    logic              init;
    logic              eoi;
    logic [LVL_W-1:0]  eoi_lvl;
    logic [N-1:0]      prev_q;
    logic [N-1:0]      irr_q;
    logic [N-1:0]      hold;
    logic [N-1:0]      nest;
    logic [N-1:0]      elig;
    logic              any;
    logic [LVL_W-1:0]  lvl_q;
    logic              spur_q;
    logic              first_ack;
    logic              second_ack;

    pic_cfg #(.N(N), .LVL_W(LVL_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .a0_i(a0_i), .wdata_i(wdata_i),
        .base_o(base), .cas_o(cas_o), .imr_o(imr), .rd_isr_o(rd_isr),
        .init_o(init), .eoi_o(eoi), .eoi_lvl_o(eoi_lvl)
    );

    // A level is eligible only if nothing at or above its priority is in service.
    for (genvar i = 0; i < N; i++) begin : g_nest
        assign nest[i] = ~|isr_o[i:0];
    end

    // Only a primary core holds cascade requests; a secondary's word is an identity.
    if (IS_SLAVE) begin : g_hold_none
        assign hold = '0;
    end else begin : g_hold_cas
        assign hold = cas_o[N-1:0];
    end

    assign elig       = irr_q & ~imr & nest;
    assign first_ack  = ack_i && !phase_o;
    assign second_ack = ack_i && phase_o;
    assign intr_o     = any && !phase_o;
    assign rdata_o    = a0_i ? DATA_W'(imr) : DATA_W'(rd_isr ? isr_o : irr_q);

    pic_prio #(.N(N), .LVL_W(LVL_W)) i_prio (
        .req_i(elig), .any_o(any), .idx_o(pick_o)
    );

    // Input edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= in_i;
    end

    // Request register: set on rising edge, dropped on a fallen line, taken at first ack.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            irr_q <= '0;
        end else begin
            irr_q <= ((irr_q | (in_i & ~prev_q)) & (in_i | hold))
                     & ~((first_ack && any) ? (N'(1) << pick_o) : '0);
        end
    end

    // In-service register: set at first ack, cleared by the specific end-of-service command.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            isr_o <= '0;
        end else begin
            isr_o <= (isr_o | ((first_ack && any) ? (N'(1) << pick_o) : '0))
                     & ~(eoi ? (N'(1) << eoi_lvl) : '0);
        end
    end

    // Acknowledge phase, frozen level and vector output.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            phase_o <= 1'b0;
            lvl_q   <= '0;
            spur_q  <= 1'b0;
            vec_o   <= '0;
            vv_o    <= 1'b0;
        end else begin
            vv_o <= second_ack;
            if (first_ack) begin
                phase_o <= 1'b1;
                lvl_q   <= pick_o;
                spur_q  <= !any;
            end
            if (second_ack) begin
                phase_o <= 1'b0;
                vec_o   <= base | DATA_W'(spur_q ? SPUR_LVL : lvl_q);
            end
        end
    end
endmodule

// File: rtl/pic_pair.sv
// Primary/secondary controller pair: the secondary's interrupt feeds primary
// input CAS_LVL, and acknowledges of that level are routed to the secondary.
// Assumes one secondary, at CAS_LVL.
module pic_pair
    import pic_pkg::*;
#(
    parameter int N_IN    = 8,
    parameter int CAS_LVL = 2,
    parameter int LVL_W   = $clog2(N_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   irq_m_i,
    input  logic [N_IN-1:0]   irq_s_i,
    input  logic              sel_slave_i,
    input  logic              a0_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              inta_i,
    output logic              intr_o,
    output logic [DATA_W-1:0] vec_o,
    output logic              vec_valid_o
);
    logic [N_IN-1:0]   m_in;
    logic [LVL_W-1:0]  m_pick, s_pick;
    logic              m_phase, s_phase;
    logic [N_IN-1:0]   m_isr, s_isr;
    logic [DATA_W-1:0] m_cas, s_cas;
    logic [DATA_W-1:0] m_rdata, s_rdata;
    logic [DATA_W-1:0] m_vec, s_vec;
    logic              m_vv, s_vv;
    logic              s_intr;
    logic              route_now;
    logic              route_q;
    logic              s_ack;

    // Primary inputs: the cascade level follows the secondary when configured.
    for (genvar k = 0; k < N_IN; k++) begin : g_min
        if (k == CAS_LVL) begin : g_cas
            assign m_in[k] = m_cas[k] ? s_intr : irq_m_i[k];
        end else begin : g_pin
            assign m_in[k] = irq_m_i[k];
        end
    end

    assign route_now = intr_o && m_cas[m_pick] && (m_pick == LVL_W'(CAS_LVL))
                       && (s_cas == DATA_W'(CAS_LVL));
    assign s_ack       = inta_i && (m_phase ? route_q : route_now);
    assign rdata_o     = sel_slave_i ? s_rdata : m_rdata;
    assign vec_o       = route_q ? s_vec : m_vec;
    assign vec_valid_o = m_vv;

    // Remember at the first acknowledge whether the secondary owns this interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)                  route_q <= 1'b0;
        else if (inta_i && !m_phase) route_q <= route_now;
    end

    pic_core #(.N(N_IN), .IS_SLAVE(1'b0), .LVL_W(LVL_W)) i_master (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i && !sel_slave_i), .a0_i(a0_i),
        .wdata_i(wdata_i), .in_i(m_in), .ack_i(inta_i), .intr_o(intr_o),
        .pick_o(m_pick), .phase_o(m_phase), .isr_o(m_isr), .cas_o(m_cas),
        .rdata_o(m_rdata), .vec_o(m_vec), .vv_o(m_vv)
    );

    pic_core #(.N(N_IN), .IS_SLAVE(1'b1), .LVL_W(LVL_W)) i_slave (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i && sel_slave_i), .a0_i(a0_i),
        .wdata_i(wdata_i), .in_i(irq_s_i), .ack_i(s_ack), .intr_o(s_intr),
        .pick_o(s_pick), .phase_o(s_phase), .isr_o(s_isr), .cas_o(s_cas),
        .rdata_o(s_rdata), .vec_o(s_vec), .vv_o(s_vv)
    );
endmodule

// File: rtl/pic_pair_chk.sv
// Property checker for pic_pair, attached with bind below.
module pic_pair_chk #(
    parameter int N_IN  = 8,
    parameter int LVL_W = $clog2(N_IN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inta_i,
    input logic             wr_i,
    input logic             a0_i,
    input logic             sel_slave_i,
    input logic             vec_valid_o,
    input logic             s_vv,
    input logic [N_IN-1:0]  m_isr,
    input logic [N_IN-1:0]  s_isr,
    input logic [LVL_W-1:0] s_pick,
    input logic             s_phase,
    input logic             route_q
);
    // R3
    vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);
    // R3
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(inta_i));
    // R7
    isr_set_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(m_isr & ~$past(m_isr))) |-> $past(inta_i));
    // R7
    isr_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(m_isr & ~$past(m_isr)) <= 1);
    // R8
    isr_clear_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(m_isr) & ~m_isr)) |-> $past(wr_i && !a0_i && !sel_slave_i));
    // R6
    slave_isr_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(s_isr & ~$past(s_isr))) |-> s_isr[$past(s_pick)]);
    // R10
    slave_phase_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_phase || s_vv) |-> route_q);
endmodule

bind pic_pair pic_pair_chk #(.N_IN(N_IN), .LVL_W(LVL_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .inta_i(inta_i), .wr_i(wr_i), .a0_i(a0_i),
    .sel_slave_i(sel_slave_i), .vec_valid_o(vec_valid_o), .s_vv(s_vv),
    .m_isr(m_isr), .s_isr(s_isr), .s_pick(s_pick), .s_phase(s_phase),
    .route_q(route_q)
);

// File: tb/test_pic_pair.sv
module test_pic_pair;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_m = '0, irq_s = '0;
    logic       sel_slave = 1'b0, a0 = 1'b0, wr = 1'b0, inta = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, vec;
    logic       intr, vec_valid;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    pic_pair i_pic_pair (
        .clk(clk), .rst_n(rst_n), .irq_m_i(irq_m), .irq_s_i(irq_s),
        .sel_slave_i(sel_slave), .a0_i(a0), .wr_i(wr), .wdata_i(wdata),
        .rdata_o(rdata), .inta_i(inta), .intr_o(intr), .vec_o(vec),
        .vec_valid_o(vec_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic s, input logic a, input logic [7:0] d);
        @(negedge clk);
        sel_slave = s; a0 = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic s, input logic a, output logic [7:0] d);
        @(negedge clk);
        sel_slave = s; a0 = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Two acknowledge pulses; returns the vector, its valid flag and intr between pulses.
    task automatic ack(output logic [7:0] v, output logic vv, output logic mid);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0; mid = intr;
        @(negedge clk); inta = 1'b1;
        @(negedge clk); v = vec; vv = vec_valid; inta = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 intr", {7'b0, intr}, 8'h00);
        check("R1 vec_valid", {7'b0, vec_valid}, 8'h00);
        rd_reg(1'b0, 1'b0, d); check("R1 primary request", d, 8'h00);
        rd_reg(1'b0, 1'b1, d); check("R1 primary mask", d, 8'hFF);
        rd_reg(1'b1, 1'b1, d); check("R1 secondary mask", d, 8'hFF);
    endtask

    task automatic t_setup();
        logic [7:0] d;
        wr_reg(1'b0, 1'b0, 8'h11); wr_reg(1'b0, 1'b1, 8'h20);
        wr_reg(1'b0, 1'b1, 8'h04); wr_reg(1'b0, 1'b1, 8'h01);
        wr_reg(1'b1, 1'b0, 8'h11); wr_reg(1'b1, 1'b1, 8'h28);
        wr_reg(1'b1, 1'b1, 8'h02); wr_reg(1'b1, 1'b1, 8'h01);
        rd_reg(1'b0, 1'b1, d); check("R2 setup words kept out of mask", d, 8'hFF);
        wr_reg(1'b0, 1'b1, 8'h00); wr_reg(1'b1, 1'b1, 8'h00);
        rd_reg(1'b0, 1'b1, d); check("R4 mask readback", d, 8'h00);
    endtask

    task automatic t_basic();
        logic [7:0] v, d; logic vv, mid;
        @(negedge clk) irq_m[5] = 1'b1;
        settle();
        check("R5 rising edge raises intr", {7'b0, intr}, 8'h01);
        ack(v, vv, mid);
        check("R3 vector level 5", v, 8'h25);
        check("R3 vector valid", {7'b0, vv}, 8'h01);
        check("R7 intr low between pulses", {7'b0, mid}, 8'h00);
        settle();
        check("R5 held input no new request", {7'b0, intr}, 8'h00);
        rd_reg(1'b0, 1'b0, d); check("R7 request cleared", d, 8'h00);
        wr_reg(1'b0, 1'b0, 8'h0B);
        rd_reg(1'b0, 1'b0, d); check("R9 in-service readback", d, 8'h20);
        wr_reg(1'b0, 1'b0, 8'h08);
        rd_reg(1'b0, 1'b0, d); check("R9 selection kept", d, 8'h20);
        wr_reg(1'b0, 1'b0, 8'h20);
        rd_reg(1'b0, 1'b0, d); check("R8 other code ignored", d, 8'h20);
        wr_reg(1'b0, 1'b0, 8'h65);
        rd_reg(1'b0, 1'b0, d); check("R8 specific clears level 5", d, 8'h00);
        wr_reg(1'b0, 1'b0, 8'h0A);
        @(negedge clk) irq_m[5] = 1'b0;
    endtask

    task automatic t_priority();
        logic [7:0] v; logic vv, mid;
        @(negedge clk) begin irq_m[3] = 1'b1; irq_m[6] = 1'b1; end
        settle();
        ack(v, vv, mid); check("R6 lowest index first", v, 8'h23);
        settle();
        check("R6 lower priority blocked", {7'b0, intr}, 8'h00);
        wr_reg(1'b0, 1'b0, 8'h63);
        settle();
        check("R6 released after service end", {7'b0, intr}, 8'h01);
        ack(v, vv, mid); check("R6 second vector", v, 8'h26);
        @(negedge clk) irq_m[1] = 1'b1;
        settle();
        check("R6 higher level nests", {7'b0, intr}, 8'h01);
        ack(v, vv, mid); check("R6 nested vector", v, 8'h21);
        wr_reg(1'b0, 1'b0, 8'h61); wr_reg(1'b0, 1'b0, 8'h66);
        @(negedge clk) irq_m = '0;
    endtask

    task automatic t_mask();
        logic [7:0] v, d; logic vv, mid;
        wr_reg(1'b0, 1'b1, 8'h10);
        rd_reg(1'b0, 1'b1, d); check("R4 mask readback 0x10", d, 8'h10);
        @(negedge clk) irq_m[4] = 1'b1;
        settle();
        check("R4 masked input silent", {7'b0, intr}, 8'h00);
        rd_reg(1'b0, 1'b0, d); check("R4 masked request latched", d, 8'h10);
        wr_reg(1'b0, 1'b1, 8'h00);
        settle();
        check("R4 unmask raises intr", {7'b0, intr}, 8'h01);
        ack(v, vv, mid); check("R4 vector level 4", v, 8'h24);
        wr_reg(1'b0, 1'b0, 8'h64);
        @(negedge clk) irq_m[4] = 1'b0;
    endtask

    task automatic t_spur_primary();
        logic [7:0] v, d; logic vv, mid;
        @(negedge clk) irq_m[0] = 1'b1;
        settle();
        check("R5 level 0 raised", {7'b0, intr}, 8'h01);
        @(negedge clk) irq_m[0] = 1'b0;
        settle();
        rd_reg(1'b0, 1'b0, d); check("R5 fallen input drops request", d, 8'h00);
        ack(v, vv, mid); check("R11 spurious vector", v, 8'h27);
        wr_reg(1'b0, 1'b0, 8'h0B);
        rd_reg(1'b0, 1'b0, d); check("R11 no in-service bit", d, 8'h00);
    endtask

    task automatic t_cascade();
        logic [7:0] v, d; logic vv, mid;
        wr_reg(1'b1, 1'b0, 8'h0B);
        @(negedge clk) irq_s[1] = 1'b1;
        settle();
        check("R10 secondary request reaches intr", {7'b0, intr}, 8'h01);
        ack(v, vv, mid); check("R10 secondary vector", v, 8'h29);
        rd_reg(1'b0, 1'b0, d); check("R10 primary level 2 in service", d, 8'h04);
        rd_reg(1'b1, 1'b0, d); check("R10 secondary level 1 in service", d, 8'h02);
        wr_reg(1'b1, 1'b0, 8'h61);
        rd_reg(1'b1, 1'b0, d); check("R10 secondary cleared", d, 8'h00);
        rd_reg(1'b0, 1'b0, d); check("R10 primary still in service", d, 8'h04);
        wr_reg(1'b0, 1'b0, 8'h62);
        rd_reg(1'b0, 1'b0, d); check("R10 primary cleared", d, 8'h00);
        @(negedge clk) irq_s[1] = 1'b0;
        settle();
    endtask

    task automatic t_spur_secondary();
        logic [7:0] v, d; logic vv, mid;
        @(negedge clk) irq_s[6] = 1'b1;
        settle();
        @(negedge clk) irq_s[6] = 1'b0;
        settle();
        check("R11 cascade request held", {7'b0, intr}, 8'h01);
        ack(v, vv, mid); check("R11 secondary spurious vector", v, 8'h2F);
        rd_reg(1'b0, 1'b0, d); check("R11 primary level 2 set", d, 8'h04);
        rd_reg(1'b1, 1'b0, d); check("R11 secondary nothing set", d, 8'h00);
        wr_reg(1'b0, 1'b0, 8'h62);
    endtask

    task automatic t_resetup();
        logic [7:0] v, d; logic vv, mid;
        wr_reg(1'b0, 1'b0, 8'h12); wr_reg(1'b0, 1'b1, 8'h40);
        wr_reg(1'b0, 1'b1, 8'h5A);
        rd_reg(1'b0, 1'b1, d); check("R2 short sequence then mask", d, 8'h5A);
        rd_reg(1'b0, 1'b0, d); check("R2 readback back to request", d, 8'h00);
        @(negedge clk) irq_m[2] = 1'b1;
        settle();
        ack(v, vv, mid); check("R2 new base, pin 2 in single mode", v, 8'h42);
        @(negedge clk) irq_m[2] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_setup();
        t_basic();
        t_priority();
        t_mask();
        t_spur_primary();
        t_cascade();
        t_spur_secondary();
        t_resetup();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule